// File: doc/BRIEF.md
# Legacy Aperture Window Decoder

This block sits between a host bus and the display memory of a VGA-style graphics controller. Each host access into the legacy aperture arrives with a byte address, a read/write flag and a linear-mode flag. The block decides whether the access lands inside the window the controller currently exposes. For an access that lands inside, it produces the offset into display memory. For an access that falls outside, it says how the access must end: a write is dropped, and a read returns all ones.

Four window layouts are available. The first claims the whole 128 KiB span. The second claims only the lower 64 KiB and moves it by a bank offset, with separate banks for reads and writes. The third and fourth each claim one 32 KiB slice of the upper half. A small register port loads the layout select and the two bank offsets. In linear mode the window logic is skipped and the host address is used directly. Results appear one clock after the request strobe and stay put until the next request.

Top module: `vga_aperture_decode`

## Requirements
- R1: After reset, done, hit, write-drop and read-fill are 0 and the offset is 0; layout 0 is selected and both banks are 0.
- R2: In layout 0 every non-linear access hits, and the offset is the host address reduced to its low 17 bits.
- R3: In layout 1, an access hits only when the 17-bit address is below 0x10000. A hit's offset is that address plus the read bank for reads, or plus the write bank for writes, wrapping modulo 2^OFF_W.
- R4: In layout 2, an access hits only when the 17-bit address lies in 0x10000..0x17FFF, and the offset is the address minus 0x10000.
- R5: In layout 3, an access hits only when the 17-bit address lies in 0x18000..0x1FFFF, and the offset is the address minus 0x18000.
- R6: An access that misses has hit=0 and offset=0. A write miss raises write-drop, and a read miss raises read-fill, which tells the host to return 0xFF. At most one of hit, write-drop and read-fill is 1.
- R7: With req_linear=1 the access always hits, and the offset is req_addr[OFF_W-1:0]. The layout and the banks have no effect.
- R8: done is 1 exactly one cycle after a cycle with req_valid=1. The other outputs take that request's result in the same cycle and hold it until the next request.
- R9: A config write with cfg_addr=0 takes the layout from cfg_data[3:2]. cfg_addr=1 loads the read bank and cfg_addr=2 loads the write bank. cfg_addr=3 changes nothing.
- R10: A config write made in the same cycle as a request applies only to later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 2 | Config target: 0 layout, 1 read bank, 2 write bank |
| cfg_data | input | OFF_W | Config write data |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_linear | input | 1 | Skip window decode |
| req_addr | input | HADDR_W | Host byte address |
| done | output | 1 | Result strobe, one cycle after the request |
| hit | output | 1 | Access lands inside the window |
| wr_drop | output | 1 | Write missed and must be discarded |
| rd_fill | output | 1 | Read missed, so return 0xFF |
| offset | output | OFF_W | Display-memory offset for a hit |

## Verification
Each layout is driven with addresses one below, at, and one above each of its window edges, so an off-by-one in a bound or a subtraction shows up as a wrong hit or a wrong offset. Layout 1 uses different read and write banks, and one write bank that forces a wrap, so a swapped bank or a truncated add can be seen. Linear requests are sent while layout 3 and non-zero banks are active, which shows that the bypass really ignores them. Config writes that coincide with requests, writes to the unused config slot, and idle stretches after a result test the ordering and hold rules.

// File: rtl/vga_aperture_decode.sv
module vga_aperture_decode #(
  parameter int OFF_W   = 22,
  parameter int HADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [OFF_W-1:0]   cfg_data,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_linear,
  input  logic [HADDR_W-1:0] req_addr,
  output logic               done,
  output logic               hit,
  output logic               wr_drop,
  output logic               rd_fill,
  output logic [OFF_W-1:0]   offset
);
  localparam int WIN_W = 17;
  localparam int PAD_W = OFF_W - WIN_W;

  logic [1:0]       map_q;
  logic [OFF_W-1:0] rbank_q, wbank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= 2'd0;
      rbank_q <= '0;
      wbank_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    map_q   <= cfg_data[3:2];
        2'd1:    rbank_q <= cfg_data;
        2'd2:    wbank_q <= cfg_data;
        default: ;
      endcase
    end
  end

  wire [WIN_W-1:0] a17  = req_addr[WIN_W-1:0];
  wire [OFF_W-1:0] win  = {{PAD_W{1'b0}}, a17};
  wire [OFF_W-1:0] slc  = {{(OFF_W-15){1'b0}}, a17[14:0]};
  wire [OFF_W-1:0] bank = req_write ? wbank_q : rbank_q;

  logic             c_hit;
  logic [OFF_W-1:0] c_off;

  always_comb begin
    c_hit = 1'b1;
    c_off = win;
    if (req_linear) begin
      c_off = req_addr[OFF_W-1:0];
    end else begin
      case (map_q)
        2'd0: c_off = win;
        2'd1: begin
          c_hit = ~a17[16];
          c_off = win + bank;
        end
        2'd2: begin
          c_hit = (a17[16:15] == 2'b10);
          c_off = slc;
        end
        default: begin
          c_hit = (a17[16:15] == 2'b11);
          c_off = slc;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      hit     <= 1'b0;
      wr_drop <= 1'b0;
      rd_fill <= 1'b0;
      offset  <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        hit     <= c_hit;
        wr_drop <= ~c_hit & req_write;
        rd_fill <= ~c_hit & ~req_write;
        offset  <= c_hit ? c_off : '0;
      end
    end
  end
endmodule

// File: rtl/vga_aperture_decode_chk.sv
module vga_aperture_decode_chk #(
  parameter int OFF_W   = 22,
  parameter int HADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic               req_linear,
  input logic [1:0]         map_sel,
  input logic               done,
  input logic               hit,
  input logic               wr_drop,
  input logic               rd_fill,
  input logic [OFF_W-1:0]   offset
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done); // R8
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(hit) && $stable(offset) && $stable(wr_drop) && $stable(rd_fill))); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> offset == '0); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, wr_drop, rd_fill})); // R6
  AST_WRITE_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rd_fill); // R6
  AST_LINEAR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_linear) |=> hit); // R7
  AST_SLICE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_linear && map_sel[1]) |=> offset < 'h8000); // R4 R5
endmodule

bind vga_aperture_decode vga_aperture_decode_chk #(.OFF_W(OFF_W), .HADDR_W(HADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_linear(req_linear), .map_sel(map_q), .done(done), .hit(hit),
  .wr_drop(wr_drop), .rd_fill(rd_fill), .offset(offset)
);

// File: tb/tb_vga_aperture_decode.sv
`timescale 1ns/1ps
module tb_vga_aperture_decode;
  localparam int OFF_W = 22;
  localparam int HADDR_W = 32;
  localparam int EXP_W = OFF_W + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [OFF_W-1:0] cfg_data = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_linear = 1'b0;
  logic [HADDR_W-1:0] req_addr = '0;
  logic done, hit, wr_drop, rd_fill;
  logic [OFF_W-1:0] offset;

  int checks = 0, errors = 0;
  logic [EXP_W-1:0] expq[$];
  string tagq[$];
  logic [EXP_W-1:0] last_exp = '0;

  logic [1:0] m_map = 2'd0;
  logic [OFF_W-1:0] m_rb = '0, m_wb = '0;

  always #2.5 clk = ~clk;

  vga_aperture_decode #(.OFF_W(OFF_W), .HADDR_W(HADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_write(req_write), .req_linear(req_linear), .req_addr(req_addr),
    .done(done), .hit(hit), .wr_drop(wr_drop), .rd_fill(rd_fill), .offset(offset)
  );

  function automatic logic [EXP_W-1:0] model(input logic w, input logic lin, input logic [HADDR_W-1:0] a);
    longint unsigned x, o, lo, hi;
    logic h;
    x = longint'(a) & 64'h1FFFF;
    h = 1'b1;
    o = x;
    if (lin) o = longint'(a) % (64'd1 << OFF_W);
    else begin
      case (m_map)
        2'd0: begin lo = 0; hi = 64'h20000; end
        2'd1: begin lo = 0; hi = 64'h10000; end
        2'd2: begin lo = 64'h10000; hi = 64'h18000; end
        default: begin lo = 64'h18000; hi = 64'h20000; end
      endcase
      h = (x >= lo) && (x < hi);
      o = x - lo;
      if (m_map == 2'd1) o = (x + longint'(w ? m_wb : m_rb)) % (64'd1 << OFF_W);
    end
    if (!h) o = 0;
    return {h, ~h & w, ~h & ~w, o[OFF_W-1:0]};
  endfunction

  task automatic check(input string tag, input logic [EXP_W-1:0] act, input logic [EXP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got hit=%0b drop=%0b fill=%0b off=%h, expected hit=%0b drop=%0b fill=%0b off=%h",
               tag, act[EXP_W-1], act[EXP_W-2], act[EXP_W-3], act[OFF_W-1:0],
               exp[EXP_W-1], exp[EXP_W-2], exp[EXP_W-3], exp[OFF_W-1:0]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) begin
        check("R8 unexpected done", {hit, wr_drop, rd_fill, offset}, '1);
      end else begin
        last_exp = expq.pop_front();
        check(tagq.pop_front(), {hit, wr_drop, rd_fill, offset}, last_exp);
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] ad, input logic [OFF_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (ad)
      2'd0: m_map = d[3:2];
      2'd1: m_rb = d;
      2'd2: m_wb = d;
      default: ;
    endcase
  endtask

  task automatic req(input string tag, input logic w, input logic lin, input logic [HADDR_W-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_linear = lin; req_addr = a;
    expq.push_back(model(w, lin, a));
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic req_with_cfg(input string tag, input logic w, input logic [HADDR_W-1:0] a,
                              input logic [1:0] ad, input logic [OFF_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_linear = 1'b0; req_addr = a;
    cfg_we = 1'b1; cfg_addr = ad; cfg_data = d;
    expq.push_back(model(w, 1'b0, a));
    tagq.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    case (ad)
      2'd0: m_map = d[3:2];
      2'd1: m_rb = d;
      2'd2: m_wb = d;
      default: ;
    endcase
  endtask

  task automatic idle_hold(input int n);
    repeat (n) begin
      @(negedge clk);
      check("R8 hold", {hit, wr_drop, rd_fill, offset}, last_exp);
      check("R8 no done when idle", {{(EXP_W-1){1'b0}}, done}, '0);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {done, hit, wr_drop, rd_fill, offset}, '0);

    req("R1 R2 layout0 zero", 1'b0, 1'b0, 32'h0);
    req("R2 layout0 top", 1'b1, 1'b0, 32'h1FFFF);
    req("R2 layout0 high bits dropped", 1'b0, 1'b0, 32'hA1234);
    idle_hold(3);

    cfg_wr(2'd1, 22'h030000);
    cfg_wr(2'd2, 22'h3FFFF0);
    cfg_wr(2'd0, 22'h4);
    req("R3 layout1 read low", 1'b0, 1'b0, 32'h00010);
    req("R3 layout1 read edge", 1'b0, 1'b0, 32'h0FFFF);
    req("R3 R6 layout1 read miss", 1'b0, 1'b0, 32'h10000);
    req("R3 layout1 write wraps", 1'b1, 1'b0, 32'h00020);
    req("R3 R6 layout1 write miss", 1'b1, 1'b0, 32'h1FFFF);
    idle_hold(2);

    cfg_wr(2'd0, 22'h8);
    req("R4 R6 layout2 below", 1'b0, 1'b0, 32'h0FFFF);
    req("R4 layout2 base", 1'b1, 1'b0, 32'h10000);
    req("R4 layout2 top", 1'b0, 1'b0, 32'h17FFF);
    req("R4 R6 layout2 above", 1'b1, 1'b0, 32'h18000);

    cfg_wr(2'd0, 22'hC);
    req("R5 R6 layout3 below", 1'b0, 1'b0, 32'h17FFF);
    req("R5 layout3 base", 1'b0, 1'b0, 32'h18000);
    req("R5 layout3 top", 1'b1, 1'b0, 32'h3FFFF);

    req("R7 linear read", 1'b0, 1'b1, 32'h003ABCDE);
    req("R7 linear write", 1'b1, 1'b1, 32'hFFC12345);
    idle_hold(2);

    cfg_wr(2'd3, 22'h0);
    req("R9 slot3 leaves layout3", 1'b0, 1'b0, 32'h0100);

    req_with_cfg("R10 old layout used", 1'b0, 32'h00100, 2'd0, 22'h4);
    req("R10 new layout applied", 1'b0, 32'h00100, 1'b0 ? 32'h0 : 32'h00100);
    req_with_cfg("R10 old read bank used", 1'b0, 32'h00200, 2'd1, 22'h000100);
    req("R9 R10 new read bank", 1'b0, 1'b0, 32'h00200);

    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R8: got %0d pending results, expected 0", expq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule